// File: doc/BRIEF.md
# Wash Motor Cycle Sequencer

This block sequences the drum motor of a timed washing machine. After a start key press it drives the motor through a fixed loop. The motor turns forward for 20 seconds, rests for 10 seconds, turns in reverse for 20 seconds, then rests for another 10 seconds. The loop repeats until a separate wash timer reports that the wash time is up. The motor then stops and a done flag goes high. That flag feeds the alarm logic and stays set until reset.

Second timing comes from a built-in clock divider, whose count per second is a parameter (50,000,000 at 50 MHz). A simulation can shrink that count to a few cycles. Any external one-second strobe on `sec_strobe_i` is also counted. Setting the divider parameter to 0 leaves the external strobe as the only source. The minute countdown, the display and the alarm tone lie outside this block.

Top module: `wash_cycle_seq`

## Requirements
- R1: An asynchronous active-low reset returns the block at once to idle, with both motor drives, all three indicators and the done flag low.
- R2: In idle the block waits. A clock edge that samples `start_key_n` low moves it to forward rotation, and `fwd_lamp_o` and `drive_fwd_o` are high in the next cycle.
- R3: Forward rotation lasts exactly FWD_SEC seconds, where one second is CLK_PER_SEC clock cycles (100 cycles with FWD_SEC=20 and CLK_PER_SEC=5).
- R4: Forward rotation is followed by a pause of exactly PAUSE_SEC seconds, with `pause_lamp_o` high and both drives low.
- R5: The first pause is followed by reverse rotation for exactly REV_SEC seconds. Reverse rotation is followed by a second pause of PAUSE_SEC seconds.
- R6: After the second pause the block returns to forward rotation and repeats the loop.
- R7: If `wash_expired_i` is sampled high during any washing phase, the next cycle shows done high and both drives low. The current phase is not finished.
- R8: The done state persists, and start key presses have no effect on it, until reset.
- R9: While washing, exactly one of the forward, reverse and pause indicators is high. In idle and done, all three are low.
- R10: `drive_fwd_o` and `drive_rev_o` are never high in the same cycle. Each one follows its own indicator.
- R11: Every clock cycle in which `sec_strobe_i` is high during washing counts as one second. With the strobe held high, forward rotation lasts FWD_SEC cycles and a pause lasts PAUSE_SEC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_key_n | input | 1 | Start key, low when pressed, already synchronous to clk |
| sec_strobe_i | input | 1 | External one-second strobe, counted in addition to the divider; tie low if unused |
| wash_expired_i | input | 1 | High when the wash timer has run out |
| drive_fwd_o | output | 1 | Motor forward drive |
| drive_rev_o | output | 1 | Motor reverse drive |
| fwd_lamp_o | output | 1 | Forward indicator |
| rev_lamp_o | output | 1 | Reverse indicator |
| pause_lamp_o | output | 1 | Pause indicator |
| done_o | output | 1 | Machine stopped after expiry |

## Verification
One complete loop runs with only the divider active. The bench measures every phase length in cycles, which separates the forward, pause and reverse limits and shows the return to forward. A second run holds the external strobe high, so phase lengths shrink to one cycle per second; this tells strobe counting apart from divider counting. Expiry is raised partway through a forward phase, which tells an immediate stop apart from finishing the phase. Start presses in idle-without-start, in done and during reset show that the state is held where it should be.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_FWD     = 3'd1,
    WS_PAUSE_A = 3'd2,
    WS_REV     = 3'd3,
    WS_PAUSE_B = 3'd4,
    WS_DONE    = 3'd5
  } wash_state_t;

  function automatic logic is_washing(input wash_state_t s);
    return (s == WS_FWD) || (s == WS_PAUSE_A) || (s == WS_REV) || (s == WS_PAUSE_B);
  endfunction

endpackage

// File: rtl/wcs_rst_sync.sv
module wcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_core_n = sync_q;

endmodule

// File: rtl/wcs_sec_tick.sv
module wcs_sec_tick #(
  parameter int CLK_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ext_strobe_i,
  output logic tick_o
);

  generate
    if (CLK_PER_SEC == 0) begin : g_ext_only
      assign tick_o = run_i & ext_strobe_i;
    end else begin : g_divider
      localparam int DIV_W = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
      localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_PER_SEC - 1);

      logic [DIV_W-1:0] cnt_q;
      logic [DIV_W-1:0] cnt_d;
      logic             div_hit;

      assign div_hit = run_i && (cnt_q == LAST);

      always_comb begin
        if (!run_i) begin
          cnt_d = '0;
        end else if (cnt_q == LAST) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick_o = div_hit | (run_i & ext_strobe_i);
    end
  endgenerate

endmodule

// File: rtl/wcs_phase_timer.sv
module wcs_phase_timer
  import wcs_pkg::*;
#(
  parameter int FWD_SEC   = 20,
  parameter int PAUSE_SEC = 10,
  parameter int REV_SEC   = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  wash_state_t state_i,
  input  logic        tick_i,
  output logic        phase_end_o
);

  localparam int MAX_A  = (FWD_SEC > REV_SEC) ? FWD_SEC : REV_SEC;
  localparam int MAX_S  = (MAX_A > PAUSE_SEC) ? MAX_A : PAUSE_SEC;
  localparam int CNT_W  = $clog2(MAX_S + 1);

  logic [CNT_W-1:0] sec_q;
  logic [CNT_W-1:0] sec_d;
  logic [CNT_W-1:0] limit;
  logic             washing;

  assign washing = is_washing(state_i);

  always_comb begin
    case (state_i)
      WS_FWD:  limit = CNT_W'(FWD_SEC);
      WS_REV:  limit = CNT_W'(REV_SEC);
      default: limit = CNT_W'(PAUSE_SEC);
    endcase
  end

  assign phase_end_o = washing && tick_i && (sec_q == limit - 1'b1);

  always_comb begin
    if (!washing || phase_end_o) begin
      sec_d = '0;
    end else if (tick_i) begin
      sec_d = sec_q + 1'b1;
    end else begin
      sec_d = sec_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else begin
      sec_q <= sec_d;
    end
  end

endmodule

// File: rtl/wcs_fsm.sv
module wcs_fsm
  import wcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_key_n,
  input  logic        expired_i,
  input  logic        phase_end_i,
  output wash_state_t state_o
);

  wash_state_t state_q;
  wash_state_t state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WS_IDLE: begin
        if (!start_key_n) state_d = WS_FWD;
      end
      WS_FWD, WS_PAUSE_A, WS_REV, WS_PAUSE_B: begin
        if (expired_i) begin
          state_d = WS_DONE;
        end else if (phase_end_i) begin
          case (state_q)
            WS_FWD:     state_d = WS_PAUSE_A;
            WS_PAUSE_A: state_d = WS_REV;
            WS_REV:     state_d = WS_PAUSE_B;
            default:    state_d = WS_FWD;
          endcase
        end
      end
      WS_DONE: state_d = WS_DONE;
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/wash_cycle_seq.sv
module wash_cycle_seq
  import wcs_pkg::*;
#(
  parameter int CLK_PER_SEC = 50_000_000,
  parameter int FWD_SEC     = 20,
  parameter int PAUSE_SEC   = 10,
  parameter int REV_SEC     = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_key_n,
  input  logic sec_strobe_i,
  input  logic wash_expired_i,
  output logic drive_fwd_o,
  output logic drive_rev_o,
  output logic fwd_lamp_o,
  output logic rev_lamp_o,
  output logic pause_lamp_o,
  output logic done_o
);

  logic        rst_core_n;
  logic        tick;
  logic        phase_end;
  logic        running;
  wash_state_t state;

  wcs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign running = is_washing(state);

  wcs_sec_tick #(
    .CLK_PER_SEC (CLK_PER_SEC)
  ) u_tick (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .run_i        (running),
    .ext_strobe_i (sec_strobe_i),
    .tick_o       (tick)
  );

  wcs_phase_timer #(
    .FWD_SEC   (FWD_SEC),
    .PAUSE_SEC (PAUSE_SEC),
    .REV_SEC   (REV_SEC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .state_i     (state),
    .tick_i      (tick),
    .phase_end_o (phase_end)
  );

  wcs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_key_n (start_key_n),
    .expired_i   (wash_expired_i),
    .phase_end_i (phase_end),
    .state_o     (state)
  );

  assign fwd_lamp_o   = (state == WS_FWD);
  assign rev_lamp_o   = (state == WS_REV);
  assign pause_lamp_o = (state == WS_PAUSE_A) || (state == WS_PAUSE_B);
  assign drive_fwd_o  = fwd_lamp_o;
  assign drive_rev_o  = rev_lamp_o;
  assign done_o       = (state == WS_DONE);

endmodule

// File: rtl/wcs_checker.sv
module wcs_checker (
  input logic clk,
  input logic rst_core_n,
  input logic start_key_n,
  input logic wash_expired_i,
  input logic drive_fwd_o,
  input logic drive_rev_o,
  input logic fwd_lamp_o,
  input logic rev_lamp_o,
  input logic pause_lamp_o,
  input logic done_o
);

  logic lamps_any;
  logic idle_now;

  assign lamps_any = fwd_lamp_o | rev_lamp_o | pause_lamp_o;
  assign idle_now  = !lamps_any && !done_o;

  AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(drive_fwd_o && drive_rev_o)); // R10

  AST_DRIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (drive_fwd_o == fwd_lamp_o) && (drive_rev_o == rev_lamp_o)); // R10

  AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_core_n)
    $countones({fwd_lamp_o, rev_lamp_o, pause_lamp_o, done_o}) <= 1); // R9

  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idle_now && !start_key_n) |=> fwd_lamp_o); // R2

  AST_EXPIRE_STOP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (lamps_any && wash_expired_i) |=> (done_o && !drive_fwd_o && !drive_rev_o)); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    done_o |=> done_o); // R8

  AST_FWD_TO_PAUSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($fell(fwd_lamp_o) && !done_o) |-> pause_lamp_o); // R4

  AST_REV_TO_PAUSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($fell(rev_lamp_o) && !done_o) |-> pause_lamp_o); // R5

endmodule

bind wash_cycle_seq wcs_checker u_chk (
  .clk            (clk),
  .rst_core_n     (rst_core_n),
  .start_key_n    (start_key_n),
  .wash_expired_i (wash_expired_i),
  .drive_fwd_o    (drive_fwd_o),
  .drive_rev_o    (drive_rev_o),
  .fwd_lamp_o     (fwd_lamp_o),
  .rev_lamp_o     (rev_lamp_o),
  .pause_lamp_o   (pause_lamp_o),
  .done_o         (done_o)
);

// File: tb/tb_wash_cycle_seq.sv
`timescale 1ns/1ps
module tb_wash_cycle_seq;

  localparam int CPS   = 5;
  localparam int FWD   = 20;
  localparam int PAU   = 10;
  localparam int REV   = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic start_key_n;
  logic sec_strobe_i;
  logic wash_expired_i;
  logic drive_fwd_o, drive_rev_o, fwd_lamp_o, rev_lamp_o, pause_lamp_o, done_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wash_cycle_seq #(
    .CLK_PER_SEC (CPS),
    .FWD_SEC     (FWD),
    .PAUSE_SEC   (PAU),
    .REV_SEC     (REV)
  ) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_key_n    (start_key_n),
    .sec_strobe_i   (sec_strobe_i),
    .wash_expired_i (wash_expired_i),
    .drive_fwd_o    (drive_fwd_o),
    .drive_rev_o    (drive_rev_o),
    .fwd_lamp_o     (fwd_lamp_o),
    .rev_lamp_o     (rev_lamp_o),
    .pause_lamp_o   (pause_lamp_o),
    .done_o         (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 1=fwd 2=rev 3=pause 0=none
  function automatic int phase_code();
    if (fwd_lamp_o && !rev_lamp_o && !pause_lamp_o) return 1;
    if (rev_lamp_o && !fwd_lamp_o && !pause_lamp_o) return 2;
    if (pause_lamp_o && !fwd_lamp_o && !rev_lamp_o) return 3;
    return 0;
  endfunction

  function automatic int outs();
    return {26'd0, drive_fwd_o, drive_rev_o, fwd_lamp_o, rev_lamp_o, pause_lamp_o, done_o};
  endfunction

  // counts negedge samples spent in phase `code`, checking drives (R10)
  task automatic run_len(input int code, output int n);
    int drive_err = 0;
    n = 0;
    while (phase_code() == code && n < 1000) begin
      n++;
      if ((drive_fwd_o && drive_rev_o) || drive_fwd_o != fwd_lamp_o || drive_rev_o != rev_lamp_o)
        drive_err++;
      @(negedge clk);
    end
    check(drive_err == 0, "R10 drives vs lamps", drive_err, 0);
  endtask

  task automatic press_start();
    start_key_n = 1'b0;
    @(negedge clk);
    start_key_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    check(outs() == 0, "R1 outputs in reset", outs(), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(outs() == 0, "R1 idle after reset", outs(), 0);
  endtask

  task automatic t_idle_hold();
    int seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (outs() != 0) seen++;
    end
    check(seen == 0, "R2 idle holds without start", seen, 0);
    check(phase_code() == 0 && !done_o, "R9 lamps off in idle", outs(), 0);
  endtask

  task automatic t_full_cycle();
    int n;
    press_start();
    check(fwd_lamp_o && drive_fwd_o, "R2 forward after start", outs(), 6'b101000);
    run_len(1, n);
    check(n == FWD * CPS, "R3 forward length", n, FWD * CPS);
    check(phase_code() == 3 && !drive_fwd_o && !drive_rev_o, "R4 pause after forward", outs(), 6'b000010);
    run_len(3, n);
    check(n == PAU * CPS, "R4 pause length", n, PAU * CPS);
    check(phase_code() == 2 && drive_rev_o, "R5 reverse after pause", outs(), 6'b010100);
    run_len(2, n);
    check(n == REV * CPS, "R5 reverse length", n, REV * CPS);
    check(phase_code() == 3, "R5 second pause", outs(), 6'b000010);
    run_len(3, n);
    check(n == PAU * CPS, "R5 second pause length", n, PAU * CPS);
    check(phase_code() == 1 && drive_fwd_o, "R6 back to forward", outs(), 6'b101000);
  endtask

  task automatic t_expire_mid();
    repeat (30) @(negedge clk);
    check(fwd_lamp_o, "R7 still forward before expiry", outs(), 6'b101000);
    wash_expired_i = 1'b1;
    @(negedge clk);
    wash_expired_i = 1'b0;
    check(done_o && outs() == 1, "R7 stop on next clock", outs(), 1);
    check(phase_code() == 0, "R9 lamps off when done", outs(), 1);
  endtask

  task automatic t_done_sticky();
    int drift = 0;
    press_start();
    repeat (2) @(negedge clk);
    press_start();
    repeat (40) begin
      @(negedge clk);
      if (outs() != 1) drift++;
    end
    check(drift == 0, "R8 done sticky, start ignored", drift, 0);
  endtask

  task automatic t_reset_from_done();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(outs() == 0, "R1 reset clears done", outs(), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(outs() == 0, "R1 idle after second reset", outs(), 0);
  endtask

  task automatic t_ext_strobe();
    int n;
    sec_strobe_i = 1'b1;
    repeat (3) @(negedge clk);
    check(outs() == 0, "R11 strobe ignored in idle", outs(), 0);
    press_start();
    run_len(1, n);
    check(n == FWD, "R11 forward with strobe", n, FWD);
    run_len(3, n);
    check(n == PAU, "R11 pause with strobe", n, PAU);
    run_len(2, n);
    check(n == REV, "R11 reverse with strobe", n, REV);
    wash_expired_i = 1'b1;
    @(negedge clk);
    wash_expired_i = 1'b0;
    sec_strobe_i = 1'b0;
    check(done_o && outs() == 1, "R7 stop during pause", outs(), 1);
  endtask

  initial begin
    rst_n          = 1'b0;
    start_key_n    = 1'b1;
    sec_strobe_i   = 1'b0;
    wash_expired_i = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_hold();
    t_full_cycle();
    t_expire_mid();
    t_done_sticky();
    t_reset_from_done();
    t_ext_strobe();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule